// File: doc/BRIEF.md
# Transmit-Only Serial Port Register Bank

This block is the host-facing register set of a serial port that only sends. A host talks to it over a byte-wide bus with a 3-bit register offset, a read strobe and a write strobe. The block answers each strobe in the same cycle with read data and an error flag. Bytes written to the data offset go straight out as a one-cycle valid/byte pair, with no queueing and no back-pressure.

Bit 7 of the line control register switches the bank that offsets 0 and 1 reach. With the bit set, those offsets reach the baud divisor halves, which are write-only. The divisor value and the FIFO control value are brought out as ports for a downstream baud generator and FIFO. The status registers always report a transmitter that is ready and idle. Accesses the map does not cover raise the error flag and change nothing.

Top module: `uart_regbank`

## Requirements
- R1: A synchronous active-high reset clears every stored register to 0x00. After reset, reads at offsets 1, 3, 4 and 7 return 0x00, `baud_div` is 0x0000, `fifo_cfg` is 0x00, and the divisor bank is deselected.
- R2: With the divisor bank deselected, writes to offset 1 (interrupt enable), 3 (line control), 4 (modem control) and 7 (scratch) are stored on the next clock edge. Reads at those offsets return the stored byte on `bus_rdata` in the cycle of the read strobe.
- R3: With the divisor bank deselected, a write to offset 0 pulses `txo_valid` in the strobe cycle, with `txo_byte` equal to the written byte, and it changes no stored register. `txo_byte` is 0x00 whenever `txo_valid` is low. A read at offset 0 is accepted and returns 0x00.
- R4: With the divisor bank deselected, reads return fixed values: offset 2 returns 0x03, offset 5 returns 0x20 and offset 6 returns 0x10.
- R5: Bit 7 of line control selects the divisor bank. While it is set, writes to offset 0 set the low byte and writes to offset 1 set the high byte of `baud_div` (high byte in bits 15:8). These writes produce no `txo_valid`.
- R6: A write to offset 2 is accepted in both banks and appears on `fifo_cfg` after the next clock edge.
- R7: A write to offset 3 is accepted in both banks. Clearing bit 7 this way returns offsets 0 and 1 to the transmit and interrupt-enable registers.
- R8: While the divisor bank is selected, writes to offsets 4 to 7 are rejected. `bus_err` is high for that strobe cycle and no stored register or output changes.
- R9: While the divisor bank is selected, every read is rejected with `bus_err` high and `bus_rdata` 0x00. In any cycle without an accepted read, `bus_rdata` is 0x00.
- R10: With the divisor bank deselected, writes to offsets 5 and 6 are rejected with `bus_err` high, and no stored register changes.
- R11: `bus_err` is high only in a cycle with a strobe whose access is rejected. Accepted accesses and idle cycles leave it low, and `txo_valid` is never high together with `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read strobe cycle |
| bus_err | output | 1 | Rejected-access pulse, in the strobe cycle |
| txo_valid | output | 1 | Transmit byte valid, one cycle |
| txo_byte | output | 8 | Transmit byte |
| baud_div | output | 16 | Stored divisor, high byte on top |
| fifo_cfg | output | 8 | Stored FIFO control byte |

## Verification
The assertions take for granted that the host never raises `bus_rd` and `bus_wr` in the same cycle. An assertion checks this, and the bench driver keeps to it by issuing exactly one strobe per access, with an idle cycle between accesses. Write and read data are assumed stable for the whole strobe cycle. The bench changes inputs just after the rising edge and samples responses at the falling edge. The stimulus crosses bank switches in both directions, so acceptance and rejection are exercised for every offset under both settings of the bank bit.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

   // storage slot indices
   localparam int SLOT_IEN   = 0;
   localparam int SLOT_LCTL  = 1;
   localparam int SLOT_MCTL  = 2;
   localparam int SLOT_SCR   = 3;
   localparam int SLOT_DLO   = 4;
   localparam int SLOT_DHI   = 5;
   localparam int SLOT_FCTL  = 6;
   localparam int NUM_SLOTS  = 7;

   // host offsets (fixed by the register map)
   localparam logic [2:0] OFS_DATA  = 3'd0;
   localparam logic [2:0] OFS_IEN   = 3'd1;
   localparam logic [2:0] OFS_IDFC  = 3'd2;
   localparam logic [2:0] OFS_LCTL  = 3'd3;
   localparam logic [2:0] OFS_MCTL  = 3'd4;
   localparam logic [2:0] OFS_LSTAT = 3'd5;
   localparam logic [2:0] OFS_MSTAT = 3'd6;
   localparam logic [2:0] OFS_SCR   = 3'd7;

   // fixed readback values
   localparam logic [7:0] ID_VALUE    = 8'h03;
   localparam logic [7:0] LSTAT_VALUE = 8'h20;
   localparam logic [7:0] MSTAT_VALUE = 8'h10;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
   import uart_regbank_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int SLOTS  = NUM_SLOTS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              dlab,
   output logic [SLOTS-1:0]  slot_we,
   output logic              tx_fire,
   output logic              rd_ok,
   output logic              reject
);

   if (ADDR_W != 3) begin : g_bad_addr
      $error("regbank_decode: ADDR_W must be 3");
   end
   if (SLOTS != NUM_SLOTS) begin : g_bad_slots
      $error("regbank_decode: SLOTS must match the package slot count");
   end

   logic wr_hit;

   always_comb begin
      slot_we = '0;
      tx_fire = 1'b0;
      if (wr) begin
         if (dlab) begin
            case (addr)
               OFS_DATA: slot_we[SLOT_DLO]  = 1'b1;
               OFS_IEN:  slot_we[SLOT_DHI]  = 1'b1;
               OFS_IDFC: slot_we[SLOT_FCTL] = 1'b1;
               OFS_LCTL: slot_we[SLOT_LCTL] = 1'b1;
               default:  slot_we = '0;
            endcase
         end else begin
            case (addr)
               OFS_DATA: tx_fire            = 1'b1;
               OFS_IEN:  slot_we[SLOT_IEN]  = 1'b1;
               OFS_IDFC: slot_we[SLOT_FCTL] = 1'b1;
               OFS_LCTL: slot_we[SLOT_LCTL] = 1'b1;
               OFS_MCTL: slot_we[SLOT_MCTL] = 1'b1;
               OFS_SCR:  slot_we[SLOT_SCR]  = 1'b1;
               default:  slot_we = '0;
            endcase
         end
      end
      wr_hit = wr && ((|slot_we) || tx_fire);
      rd_ok  = rd && !dlab;
      reject = (wr && !wr_hit) || (rd && dlab);
   end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
   parameter int          DATA_W  = 8,
   parameter int          SLOTS   = 7,
   parameter logic [7:0]  RST_VAL = 8'h00
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [SLOTS-1:0]              slot_we,
   input  logic [DATA_W-1:0]             wdata,
   output logic [SLOTS-1:0][DATA_W-1:0]  slot_q
);

   if (SLOTS < 1) begin : g_bad_slots
      $error("regbank_store: SLOTS must be positive");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)
            slot_q[g] <= DATA_W'(RST_VAL);
         else if (slot_we[g])
            slot_q[g] <= wdata;
      end
   end

endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux
   import uart_regbank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              rd_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ien_q,
   input  logic [DATA_W-1:0] lctl_q,
   input  logic [DATA_W-1:0] mctl_q,
   input  logic [DATA_W-1:0] scr_q,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] ID_W    = DATA_W'(ID_VALUE);
   localparam logic [DATA_W-1:0] LSTAT_W = DATA_W'(LSTAT_VALUE);
   localparam logic [DATA_W-1:0] MSTAT_W = DATA_W'(MSTAT_VALUE);

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         case (addr)
            OFS_DATA:  rdata = '0;
            OFS_IEN:   rdata = ien_q;
            OFS_IDFC:  rdata = ID_W;
            OFS_LCTL:  rdata = lctl_q;
            OFS_MCTL:  rdata = mctl_q;
            OFS_LSTAT: rdata = LSTAT_W;
            OFS_MSTAT: rdata = MSTAT_W;
            OFS_SCR:   rdata = scr_q;
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_regbank_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 3,
   parameter int          DLAB_BIT = 7,
   parameter logic [7:0]  RST_VAL  = 8'h00
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_err,
   output logic                txo_valid,
   output logic [DATA_W-1:0]   txo_byte,
   output logic [2*DATA_W-1:0] baud_div,
   output logic [DATA_W-1:0]   fifo_cfg
);

   localparam int DIV_W = 2 * DATA_W;

   if (DATA_W < 8) begin : g_bad_data
      $error("uart_regbank: DATA_W must be at least 8");
   end
   if (DLAB_BIT >= DATA_W) begin : g_bad_dlab
      $error("uart_regbank: DLAB_BIT must lie inside the data byte");
   end
   if (RST_VAL[DLAB_BIT % 8] != 1'b0) begin : g_bad_rst
      $error("uart_regbank: reset value must leave the bank bit clear");
   end

   logic [NUM_SLOTS-1:0]             slot_we;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
   logic                             tx_fire;
   logic                             rd_ok;
   logic                             reject;
   logic                             dlab;

   assign dlab = slot_q[SLOT_LCTL][DLAB_BIT];

   regbank_decode #(
      .ADDR_W (ADDR_W),
      .SLOTS  (NUM_SLOTS)
   ) u_decode (
      .addr    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .dlab    (dlab),
      .slot_we (slot_we),
      .tx_fire (tx_fire),
      .rd_ok   (rd_ok),
      .reject  (reject)
   );

   regbank_store #(
      .DATA_W  (DATA_W),
      .SLOTS   (NUM_SLOTS),
      .RST_VAL (RST_VAL)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .slot_we (slot_we),
      .wdata   (bus_wdata),
      .slot_q  (slot_q)
   );

   regbank_readmux #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_readmux (
      .rd_ok  (rd_ok),
      .addr   (bus_addr),
      .ien_q  (slot_q[SLOT_IEN]),
      .lctl_q (slot_q[SLOT_LCTL]),
      .mctl_q (slot_q[SLOT_MCTL]),
      .scr_q  (slot_q[SLOT_SCR]),
      .rdata  (bus_rdata)
   );

   assign bus_err   = reject;
   assign txo_valid = tx_fire;
   assign txo_byte  = tx_fire ? bus_wdata : '0;
   assign baud_div  = DIV_W'({slot_q[SLOT_DHI], slot_q[SLOT_DLO]});
   assign fifo_cfg  = slot_q[SLOT_FCTL];

   // host contract: one strobe per cycle (R11)
   p_single_strobe_r11: assert property (@(posedge clk) disable iff (rst)
      !(bus_rd && bus_wr));

   p_err_needs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
      bus_err |-> (bus_rd || bus_wr));

   p_tx_not_rejected_r3: assert property (@(posedge clk) disable iff (rst)
      txo_valid |-> (bus_wr && !bus_err));

   p_tx_keeps_regs_r3: assert property (@(posedge clk) disable iff (rst)
      txo_valid |=> $stable(slot_q));

   p_reject_keeps_regs_r8: assert property (@(posedge clk) disable iff (rst)
      bus_err |=> $stable(slot_q));

   p_bank_read_fails_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && dlab) |-> (bus_err && bus_rdata == '0));

   p_line_status_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !dlab && bus_addr == OFS_LSTAT) |-> bus_rdata == DATA_W'(LSTAT_VALUE));

   p_bank_no_tx_r5: assert property (@(posedge clk) disable iff (rst)
      dlab |-> !txo_valid);

endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_err;
   logic        txo_valid;
   logic [7:0]  txo_byte;
   logic [15:0] baud_div;
   logic [7:0]  fifo_cfg;

   always #10 clk = ~clk;   // 50 MHz

   uart_regbank dut_i (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .txo_valid (txo_valid),
      .txo_byte  (txo_byte),
      .baud_div  (baud_div),
      .fifo_cfg  (fifo_cfg)
   );

   typedef struct {
      logic [7:0] rdata;
      logic       err;
      logic       txv;
      logic [7:0] txd;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;

   // reference model of stored state
   logic [7:0] m_ien, m_lctl, m_mctl, m_scr, m_dlo, m_dhi, m_fctl;

   task automatic model_reset();
      m_ien = 0; m_lctl = 0; m_mctl = 0; m_scr = 0;
      m_dlo = 0; m_dhi = 0; m_fctl = 0;
   endtask

   // driver: computes expectation, queues it, drives one strobe
   task automatic acc(input bit wr, input logic [2:0] a, input logic [7:0] d,
                      input string req);
      exp_t e;
      bit   bank;
      bank = m_lctl[7];
      e.rdata = 8'h00; e.err = 1'b0; e.txv = 1'b0; e.txd = 8'h00; e.req = req;
      if (wr) begin
         if (bank) begin
            case (a)
               3'd0: m_dlo  = d;
               3'd1: m_dhi  = d;
               3'd2: m_fctl = d;
               3'd3: m_lctl = d;
               default: e.err = 1'b1;
            endcase
         end else begin
            case (a)
               3'd0: begin e.txv = 1'b1; e.txd = d; end
               3'd1: m_ien  = d;
               3'd2: m_fctl = d;
               3'd3: m_lctl = d;
               3'd4: m_mctl = d;
               3'd7: m_scr  = d;
               default: e.err = 1'b1;
            endcase
         end
      end else begin
         if (bank) e.err = 1'b1;
         else begin
            case (a)
               3'd0: e.rdata = 8'h00;
               3'd1: e.rdata = m_ien;
               3'd2: e.rdata = 8'h03;
               3'd3: e.rdata = m_lctl;
               3'd4: e.rdata = m_mctl;
               3'd5: e.rdata = 8'h20;
               3'd6: e.rdata = 8'h10;
               default: e.rdata = m_scr;
            endcase
         end
      end
      exp_q.push_back(e);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
   endtask

   // monitor: compares each strobe cycle with the queue head
   always @(negedge clk) begin
      if (!rst && (bus_rd || bus_wr)) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: unexpected strobe, actual rdata=%h err=%b exp none",
                     bus_rdata, bus_err);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (bus_rdata !== e.rdata || bus_err !== e.err ||
                txo_valid !== e.txv || txo_byte !== e.txd) begin
               n_fail++;
               $display("FAIL %s: actual rdata=%h err=%b txv=%b txd=%h exp rdata=%h err=%b txv=%b txd=%h",
                        e.req, bus_rdata, bus_err, txo_valid, txo_byte,
                        e.rdata, e.err, e.txv, e.txd);
            end
         end
      end
   end

   task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string req);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic cfg_chk(input string req);
      @(negedge clk);
      chk(baud_div, {m_dhi, m_dlo}, req);
      chk({8'h00, fifo_cfg}, {8'h00, m_fctl}, req);
   endtask

   task automatic idle_chk(input string req);
      @(negedge clk);
      chk({6'd0, bus_err, txo_valid, bus_rdata}, 16'h0000, req);
      chk({8'h00, txo_byte}, 16'h0000, req);
   endtask

   task automatic do_reset();
      @(posedge clk); #1; rst = 1'b1;
      repeat (3) @(posedge clk);
      #1; rst = 1'b0;
      model_reset();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      model_reset();
      do_reset();

      // R1 reset state
      cfg_chk("R1");
      idle_chk("R11");
      acc(0, 3'd1, 0, "R1"); acc(0, 3'd3, 0, "R1");
      acc(0, 3'd4, 0, "R1"); acc(0, 3'd7, 0, "R1");

      // R3 read at data offset, R4 fixed status
      acc(0, 3'd0, 0, "R3");
      acc(0, 3'd2, 0, "R4"); acc(0, 3'd5, 0, "R4"); acc(0, 3'd6, 0, "R4");

      // R2 store and read back
      acc(1, 3'd1, 8'h5A, "R2"); acc(1, 3'd4, 8'h13, "R2");
      acc(1, 3'd7, 8'hC3, "R2"); acc(1, 3'd3, 8'h1B, "R2");
      acc(0, 3'd1, 0, "R2"); acc(0, 3'd4, 0, "R2");
      acc(0, 3'd7, 0, "R2"); acc(0, 3'd3, 0, "R2");

      // R3 transmit handoff, nothing stored
      acc(1, 3'd0, 8'h41, "R3"); acc(1, 3'd0, 8'hFF, "R3");
      acc(0, 3'd1, 0, "R3"); acc(0, 3'd7, 0, "R3");
      idle_chk("R11");

      // R10 rejected writes in the normal bank
      acc(1, 3'd5, 8'hEE, "R10"); acc(1, 3'd6, 8'h77, "R10");
      acc(0, 3'd5, 0, "R10"); acc(0, 3'd6, 0, "R10");
      acc(0, 3'd4, 0, "R10"); acc(0, 3'd3, 0, "R10");

      // R6 FIFO control in the normal bank
      acc(1, 3'd2, 8'hC7, "R6");
      cfg_chk("R6");
      acc(0, 3'd2, 0, "R6");

      // R5/R7 divisor bank selected
      acc(1, 3'd3, 8'h9B, "R7");
      acc(1, 3'd0, 8'h34, "R5"); acc(1, 3'd1, 8'h12, "R5");
      cfg_chk("R5");
      acc(1, 3'd2, 8'h81, "R6");
      cfg_chk("R6");

      // R8 rejected writes in the divisor bank
      acc(1, 3'd4, 8'hAA, "R8"); acc(1, 3'd5, 8'hAB, "R8");
      acc(1, 3'd6, 8'hAC, "R8"); acc(1, 3'd7, 8'hAD, "R8");
      cfg_chk("R8");

      // R9 every read rejected in the divisor bank
      for (int i = 0; i < 8; i++) acc(0, 3'(i), 0, "R9");
      idle_chk("R11");

      // R7 leave the divisor bank; R8 no state was touched
      acc(1, 3'd3, 8'h03, "R7");
      acc(0, 3'd3, 0, "R7");
      acc(0, 3'd1, 0, "R7");
      acc(0, 3'd4, 0, "R8"); acc(0, 3'd7, 0, "R8");
      acc(1, 3'd0, 8'h5C, "R7");
      cfg_chk("R7");

      // R1 reset from a populated state
      do_reset();
      cfg_chk("R1");
      acc(0, 3'd3, 0, "R1"); acc(0, 3'd7, 0, "R1");
      acc(1, 3'd0, 8'h22, "R1");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule